// File: doc/BRIEF.md
# Mailbox Flash Command Controller

This block is the device end of a register mailbox through which a host operates a small flash store. The host sees a window of 32-bit registers: sixteen data-buffer entries, one command register and one status register, all addressed by an offset from the window base. To run an operation, the host fills the data buffer if needed and writes a command word with its request bit set. The block then copies flash contents into the buffer, programs buffer contents into flash, starts an authentication step or raises a power-cycle request.

When an operation finishes, the block clears the request bit inside the command register. That cleared bit is the only completion signal, so the host polls it. At the same moment the block posts a status word that carries a result code and echoes the opcode that produced it. The host can read this word later to learn which command the result belongs to. The flash is a behavioural array with a main region and a separate header region. The authentication and power-cycle steps are stood in for by an output pulse followed by a fixed wait set by the `LATENCY` parameter.

Top module: `mbx_ctrl`

## Requirements
- R1: Window offsets 1 to 16 map to data-buffer entries 0 to 15, offset 17 to the command register and offset 18 to the status register. Every other offset reads zero. After reset the buffer, the command register, the status register and the flash all read zero.
- R2: Command word fields are: opcode in bits 31:28 (0 = flash write, 1 = authenticate, 2 = flash read, 4 = power cycle), count in bits 27:24, dword address in bits 23:2, header-region select in bit 1, and request in bit 0. A command-register write made while idle stores the whole word. The operation starts only when bit 0 of that word is 1.
- R3: For a flash read, a count field of 0 moves 16 dwords and any other value n moves exactly n dwords. Buffer entry i receives flash dword address+i. Entries beyond the length keep their contents.
- R4: For a flash write, the number of dwords is the count field plus one, from 1 to 16. Flash dword address+i receives buffer entry i.
- R5: When bit 1 is set, a read or write targets the header region of `HDR_DWORDS` dwords, which is separate from the main region of `FLASH_DWORDS` dwords. The address is then relative to the start of the header region.
- R6: Completion clears command bit 0 and keeps bits 31:1. Counting edges from the one that accepts the request, the clear happens after n+1 edges for a read or write of n dwords, after 1 edge for a rejected command, and after `LATENCY`+1 edges for authenticate and power cycle.
- R7: On completion the status register becomes: result code in bits 3:0, opcode in bits 7:4, bit 29 set, all other bits zero. Code 0 means completed, 2 means access error and 3 means unsupported opcode. Code 1, authentication error, is reserved and is never produced by this model.
- R8: An opcode other than 0, 1, 2 or 4 completes with code 3 and changes neither the flash nor the buffer.
- R9: A read or write whose address plus length exceeds the size of the selected region completes with code 2 and moves no data. A transfer that ends exactly at the region end is allowed.
- R10: Authenticate drives `auth_pulse` and power cycle drives `pwr_pulse` high for exactly the one cycle after the accepting edge. The two are never high together. Both commands complete with code 0.
- R11: While a command is busy, host writes to the command register and to the data buffer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 5 | Register offset within the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| busy | output | 1 | A command is in progress |
| auth_pulse | output | 1 | One-cycle authenticate start pulse |
| pwr_pulse | output | 1 | One-cycle power-cycle request pulse |

## Verification
Each completion has a known due cycle: n+1 edges after acceptance for a transfer, 1 edge for a rejected command, and `LATENCY`+1 edges for the pulse commands. The bench computes this latency from the command word. It confirms the request bit is still set one sample before the due edge and cleared at the sample right after it. Pulses are sampled in the first cycle after acceptance and again in the second, where they must be low. The status word, the full buffer and, through later reads, the flash contents are compared against a bench model after every command. Random commands mix both regions, every count and addresses slightly past each region's end.

// File: rtl/mbx_pkg.sv
// Package: shared constants for the mailbox flash command controller.
// Assumes 32-bit registers and a 16-entry data buffer.
package mbx_pkg;
    localparam int BUF_DWORDS = 16;

    localparam logic [4:0] OFS_CMD  = 5'd17;
    localparam logic [4:0] OFS_STAT = 5'd18;

    localparam logic [3:0] OP_FWRITE = 4'h0;
    localparam logic [3:0] OP_AUTH   = 4'h1;
    localparam logic [3:0] OP_FREAD  = 4'h2;
    localparam logic [3:0] OP_PWR    = 4'h4;

    localparam logic [3:0] ST_OK     = 4'd0;
    localparam logic [3:0] ST_ACCESS = 4'd2;
    localparam logic [3:0] ST_BADOP  = 4'd3;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_WAIT = 2'd2,
        S_FIN  = 2'd3
    } eng_state_t;
endpackage

// File: rtl/mbx_flash.sv
// Module: behavioural flash array, main region followed by header region.
// Assumes a single access per cycle: asynchronous read, synchronous write.
// Cleared to zero by reset so contents are defined from the start.
module mbx_flash #(
    parameter int DEPTH = 80,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] mem_q [DEPTH];

    // Storage update: clear on reset, else write one dword when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    // Read port: current dword at the addressed index.
    always_comb rdata = mem_q[idx];
endmodule

// File: rtl/mbx_engine.sv
// Module: command decode and sequencing engine.
// Decodes a command word when start is raised, checks region bounds,
// moves one dword per cycle between buffer and flash, times the
// authenticate / power-cycle wait, and flags completion for one cycle.
// Assumes start is only raised while busy is low.
module mbx_engine
    import mbx_pkg::*;
#(
    parameter int FLASH_DWORDS = 64,
    parameter int HDR_DWORDS   = 16,
    parameter int LATENCY      = 8,
    parameter int IW           = 7,
    localparam int CW          = $clog2(LATENCY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:1]   cmd_word,
    output logic          busy,
    output logic          done,
    output logic [3:0]    done_op,
    output logic [3:0]    done_code,
    output logic          fl_we,
    output logic [IW-1:0] fl_idx,
    output logic [31:0]   fl_wdata,
    input  logic [31:0]   fl_rdata,
    output logic [3:0]    buf_idx,
    output logic          buf_we,
    output logic [31:0]   buf_wdata,
    input  logic [31:0]   buf_rdata,
    output logic          auth_pulse,
    output logic          pwr_pulse
);
    eng_state_t    st_q;
    logic [3:0]    op_q;
    logic [4:0]    len_q;
    logic [3:0]    idx_q;
    logic [IW-1:0] base_q;
    logic          css_q;
    logic [3:0]    code_q;
    logic [CW-1:0] wait_q;
    logic          auth_q, pwr_q;

    logic [3:0]  d_op, d_cnt;
    logic [21:0] d_adr;
    logic        d_css;
    logic [4:0]  d_len;
    logic [22:0] d_end, d_lim;
    logic        d_ok, last;

    // Field decode, length interpretation and region bound check.
    always_comb begin
        d_op  = cmd_word[31:28];
        d_cnt = cmd_word[27:24];
        d_adr = cmd_word[23:2];
        d_css = cmd_word[1];
        if (d_op == OP_FREAD) d_len = (d_cnt == 4'd0) ? 5'd16 : {1'b0, d_cnt};
        else                  d_len = {1'b0, d_cnt} + 5'd1;
        d_lim = d_css ? 23'(HDR_DWORDS) : 23'(FLASH_DWORDS);
        d_end = {1'b0, d_adr} + {18'd0, d_len};
        d_ok  = (d_end <= d_lim);
    end

    // Datapath steering for the transfer state.
    always_comb begin
        last      = (({1'b0, idx_q} + 5'd1) == len_q);
        fl_idx    = (css_q ? IW'(FLASH_DWORDS) : IW'(0)) + base_q + IW'(idx_q);
        fl_we     = (st_q == S_XFER) && (op_q == OP_FWRITE);
        fl_wdata  = buf_rdata;
        buf_idx   = idx_q;
        buf_we    = (st_q == S_XFER) && (op_q == OP_FREAD);
        buf_wdata = fl_rdata;
        busy      = (st_q != S_IDLE);
        done      = (st_q == S_FIN);
        done_op   = op_q;
        done_code = code_q;
        auth_pulse = auth_q;
        pwr_pulse  = pwr_q;
    end

    // Sequencer: accept, transfer or wait, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            op_q   <= '0;
            len_q  <= '0;
            idx_q  <= '0;
            base_q <= '0;
            css_q  <= 1'b0;
            code_q <= ST_OK;
            wait_q <= '0;
            auth_q <= 1'b0;
            pwr_q  <= 1'b0;
        end else begin
            auth_q <= 1'b0;
            pwr_q  <= 1'b0;
            unique case (st_q)
                S_IDLE: if (start) begin
                    op_q   <= d_op;
                    len_q  <= d_len;
                    idx_q  <= '0;
                    base_q <= d_adr[IW-1:0];
                    css_q  <= d_css;
                    wait_q <= '0;
                    code_q <= ST_OK;
                    case (d_op)
                        OP_FREAD, OP_FWRITE: begin
                            if (d_ok) st_q <= S_XFER;
                            else begin
                                st_q   <= S_FIN;
                                code_q <= ST_ACCESS;
                            end
                        end
                        OP_AUTH: begin
                            auth_q <= 1'b1;
                            st_q   <= S_WAIT;
                        end
                        OP_PWR: begin
                            pwr_q <= 1'b1;
                            st_q  <= S_WAIT;
                        end
                        default: begin
                            st_q   <= S_FIN;
                            code_q <= ST_BADOP;
                        end
                    endcase
                end
                S_XFER: begin
                    idx_q <= idx_q + 4'd1;
                    if (last) st_q <= S_FIN;
                end
                S_WAIT: begin
                    wait_q <= wait_q + CW'(1);
                    if (wait_q == CW'(LATENCY - 1)) st_q <= S_FIN;
                end
                S_FIN: st_q <= S_IDLE;
            endcase
        end
    end

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_pulse || pwr_pulse) |=> !(auth_pulse || pwr_pulse));
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({auth_pulse, pwr_pulse}));
    p_flash_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> (32'(fl_idx) < FLASH_DWORDS + HDR_DWORDS));
endmodule

// File: rtl/mbx_ctrl.sv
// Module: mailbox flash command controller top.
// Holds the register window (data buffer, command, status), gates host
// writes while busy, clears the request bit and posts status on completion.
// Assumes host_addr is a window offset; read data is combinational.
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int FLASH_DWORDS = 64,
    parameter int HDR_DWORDS   = 16,
    parameter int LATENCY      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [4:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        busy,
    output logic        auth_pulse,
    output logic        pwr_pulse
);
    localparam int DEPTH = FLASH_DWORDS + HDR_DWORDS;
    localparam int IW    = $clog2(DEPTH);

    logic [BUF_DWORDS-1:0][31:0] buf_q;
    logic [31:0] cmd_q, stat_q;
    logic        is_buf, is_cmd, is_stat, start;
    logic [3:0]  buf_sel;

    logic          eng_done, eng_buf_we, fl_we;
    logic [3:0]    eng_op, eng_code, eng_idx;
    logic [31:0]   eng_buf_wdata, fl_wdata, fl_rdata;
    logic [IW-1:0] fl_idx;

    // Offset decode and request detection.
    always_comb begin
        is_buf  = (host_addr >= 5'd1) && (host_addr <= 5'd16);
        is_cmd  = (host_addr == OFS_CMD);
        is_stat = (host_addr == OFS_STAT);
        buf_sel = host_addr[3:0] - 4'd1;
        start   = host_we && is_cmd && host_wdata[0] && !busy;
    end

    // Command register: host store while idle, request clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cmd_q <= '0;
        else if (host_we && is_cmd && !busy) cmd_q <= host_wdata;
        else if (eng_done)                 cmd_q[0] <= 1'b0;
    end

    // Status register: result code, echoed opcode and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        stat_q <= '0;
        else if (eng_done) stat_q <= {2'b00, 1'b1, 21'd0, eng_op, eng_code};
    end

    // Data buffer: engine fill during reads, host writes only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          buf_q <= '0;
        else if (eng_buf_we)                 buf_q[eng_idx] <= eng_buf_wdata;
        else if (host_we && is_buf && !busy) buf_q[buf_sel] <= host_wdata;
    end

    // Host read mux.
    always_comb begin
        host_rdata = '0;
        if (is_buf)       host_rdata = buf_q[buf_sel];
        else if (is_cmd)  host_rdata = cmd_q;
        else if (is_stat) host_rdata = stat_q;
    end

    mbx_engine #(
        .FLASH_DWORDS(FLASH_DWORDS),
        .HDR_DWORDS  (HDR_DWORDS),
        .LATENCY     (LATENCY),
        .IW          (IW)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_word  (host_wdata[31:1]),
        .busy      (busy),
        .done      (eng_done),
        .done_op   (eng_op),
        .done_code (eng_code),
        .fl_we     (fl_we),
        .fl_idx    (fl_idx),
        .fl_wdata  (fl_wdata),
        .fl_rdata  (fl_rdata),
        .buf_idx   (eng_idx),
        .buf_we    (eng_buf_we),
        .buf_wdata (eng_buf_wdata),
        .buf_rdata (buf_q[eng_idx]),
        .auth_pulse(auth_pulse),
        .pwr_pulse (pwr_pulse)
    );

    mbx_flash #(.DEPTH(DEPTH), .IW(IW)) u_flash (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (fl_we),
        .idx  (fl_idx),
        .wdata(fl_wdata),
        .rdata(fl_rdata)
    );

    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done && host_we && is_cmd) |=> $stable(cmd_q));
    p_buf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_buf_we && host_we && is_buf) |=> $stable(buf_q));
    p_req_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !cmd_q[0]);
    p_stat_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (stat_q[29] && stat_q[7:4] == $past(eng_op)));
endmodule

// File: tb/test_mbx_ctrl.sv
module test_mbx_ctrl;
    localparam int FLASH = 64;
    localparam int HDR   = 16;
    localparam int LAT   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy, auth_pulse, pwr_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] ref_flash [FLASH + HDR];
    logic [31:0] ref_buf [16];

    mbx_ctrl #(.FLASH_DWORDS(FLASH), .HDR_DWORDS(HDR), .LATENCY(LAT)) i_mbx_ctrl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
        .auth_pulse(auth_pulse), .pwr_pulse(pwr_pulse)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [4:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    function automatic int exp_len(input logic [31:0] c);
        if (c[31:28] == 4'h2) return (c[27:24] == 4'd0) ? 16 : int'(c[27:24]);
        return int'(c[27:24]) + 1;
    endfunction

    function automatic logic [3:0] exp_code(input logic [31:0] c);
        int lim;
        lim = c[1] ? HDR : FLASH;
        case (c[31:28])
            4'h0, 4'h2: return (int'(c[23:2]) + exp_len(c) > lim) ? 4'd2 : 4'd0;
            4'h1, 4'h4: return 4'd0;
            default:    return 4'd3;
        endcase
    endfunction

    function automatic int exp_lat(input logic [31:0] c);
        if (exp_code(c) != 4'd0) return 1;
        if (c[31:28] == 4'h1 || c[31:28] == 4'h4) return LAT + 1;
        return exp_len(c) + 1;
    endfunction

    task automatic fill_buf();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            v = $urandom;
            host_wr(5'(i + 1), v);
            ref_buf[i] = v;
        end
    endtask

    task automatic check_buf(input string tag);
        logic [31:0] d;
        for (int i = 0; i < 16; i++) begin
            host_rd(5'(i + 1), d);
            chk(tag, d, ref_buf[i]);
        end
    endtask

    task automatic apply_model(input logic [31:0] c);
        int base;
        base = (c[1] ? FLASH : 0) + int'(c[23:2]);
        if (exp_code(c) == 4'd0) begin
            if (c[31:28] == 4'h2)
                for (int i = 0; i < exp_len(c); i++) ref_buf[i] = ref_flash[base + i];
            else if (c[31:28] == 4'h0)
                for (int i = 0; i < exp_len(c); i++) ref_flash[base + i] = ref_buf[i];
        end
    endtask

    // Issue one request and check request-bit timing, pulses, status, buffer.
    task automatic run_cmd(input logic [31:0] c);
        int lat;
        logic [31:0] d;
        lat = exp_lat(c);
        host_wr(5'd17, c);
        for (int k = 0; k < lat; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 0) begin
                chk("R10 auth pulse", {31'd0, auth_pulse}, {31'd0, c[31:28] == 4'h1});
                chk("R10 pwr pulse", {31'd0, pwr_pulse}, {31'd0, c[31:28] == 4'h4});
            end
            if (k == 1) chk("R10 pulse width", {30'd0, auth_pulse, pwr_pulse}, 32'd0);
            if (k == lat - 1) begin
                host_rd(5'd17, d);
                chk("R6 request pending", {31'd0, d[0]}, 32'd1);
            end
        end
        @(negedge clk);
        host_rd(5'd17, d);
        chk("R6 request cleared", d, c & ~32'd1);
        host_rd(5'd18, d);
        chk("R7 status word", d, {2'b00, 1'b1, 21'd0, c[31:28], exp_code(c)});
        apply_model(c);
        check_buf("R3 buffer");
    endtask

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] cnt,
                                       input int adr, input logic css);
        return {op, cnt, 22'(adr), css, 1'b1};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] c;
        void'($urandom(32'h1a2b3c4d));
        for (int i = 0; i < FLASH + HDR; i++) ref_flash[i] = '0;
        for (int i = 0; i < 16; i++) ref_buf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values and unmapped offsets
        for (int a = 0; a < 32; a++) begin
            host_rd(5'(a), d);
            chk("R1 reset read", d, 32'd0);
        end
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);

        // R2: stored command without request does not start
        host_wr(5'd17, 32'h2000_0010);
        host_rd(5'd17, d);
        chk("R2 stored word", d, 32'h2000_0010);
        chk("R2 no start", {31'd0, busy}, 32'd0);

        // R4 full 16-dword write, R3 full read with count 0
        fill_buf();
        run_cmd(mk(4'h0, 4'd15, 0, 1'b0));
        fill_buf();
        run_cmd(mk(4'h2, 4'd0, 0, 1'b0));
        // R3 partial read keeps upper entries
        fill_buf();
        run_cmd(mk(4'h2, 4'd3, 5, 1'b0));
        // R4 single-dword write
        run_cmd(mk(4'h0, 4'd0, 63, 1'b0));
        run_cmd(mk(4'h2, 4'd1, 63, 1'b0));
        // R5 header region write then read both regions
        fill_buf();
        run_cmd(mk(4'h0, 4'd3, 2, 1'b1));
        run_cmd(mk(4'h2, 4'd4, 2, 1'b1));
        run_cmd(mk(4'h2, 4'd4, 2, 1'b0));
        // R9 boundaries
        run_cmd(mk(4'h2, 4'd0, 48, 1'b0));
        run_cmd(mk(4'h2, 4'd8, 60, 1'b0));
        run_cmd(mk(4'h0, 4'd3, 14, 1'b1));
        run_cmd(mk(4'h0, 4'd15, 0, 1'b1));
        // R8 unsupported opcodes
        run_cmd(mk(4'h3, 4'd2, 0, 1'b0));
        run_cmd(mk(4'hF, 4'd0, 1, 1'b0));
        // R10 authenticate and power cycle
        run_cmd(mk(4'h1, 4'd0, 0, 1'b0));
        run_cmd(mk(4'h4, 4'd0, 0, 1'b0));

        // R11: writes during a busy authenticate are ignored
        c = mk(4'h1, 4'd0, 0, 1'b0);
        host_wr(5'd17, c);
        host_wr(5'd17, mk(4'h2, 4'd0, 0, 1'b0));
        host_wr(5'd5, 32'hDEAD_BEEF);
        for (int k = 0; k < 40 && busy; k++) @(negedge clk);
        host_rd(5'd17, d);
        chk("R11 command kept", d, c & ~32'd1);
        host_rd(5'd18, d);
        chk("R11 status of first command", d, {2'b00, 1'b1, 21'd0, 4'h1, 4'd0});
        check_buf("R11 buffer unchanged");

        // Random mix
        for (int n = 0; n < 120; n++) begin
            int r, lim, adr;
            logic [3:0] op;
            logic css;
            r = int'($urandom % 10);
            if (r < 4) op = 4'h0;
            else if (r < 8) op = 4'h2;
            else if (r == 8) op = 4'h4;
            else op = 4'h3 + 4'($urandom % 2) * 4'h5;
            css = ($urandom % 4) == 0;
            lim = css ? HDR : FLASH;
            adr = int'($urandom % 32'(lim + 4));
            if (op == 4'h0 && ($urandom % 2) == 0) fill_buf();
            run_cmd(mk(op, 4'($urandom % 16), adr, css));
        end

        // R4/R5 final sweep: read back every region dword
        for (int b = 0; b < FLASH; b += 16) run_cmd(mk(4'h2, 4'd0, b, 1'b0));
        run_cmd(mk(4'h2, 4'd0, 0, 1'b1));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule